// File: doc/BRIEF.md
# Byte Window Alignment Unit

This unit runs one two-operand alignment operation against a small file of 32-bit media registers. An instruction word arrives with a valid strobe. The unit decodes the word and reads two source registers. It treats them as one eight-byte stream, with the first source as the upper half. A three-bit window code picks one of five byte-granular 32-bit slices of that stream. The slice is written into the destination register.

A host port preloads registers before a run. A combinational read port lets the host observe any register afterwards. Register 0 is hardwired to zero. Several conditions turn an instruction into a no-op:

- a word whose identifying codes do not match;
- a non-zero padding field;
- a destination of register 0;
- a window code above 4.

There is no pipeline, hazard logic or exception output. The result is committed on the clock edge that samples the valid instruction.

Top module: `byte_align_unit`

## Requirements
- R1: The instruction is recognised only when `instr_valid` is high, bits 31:26 equal 0x1C, bits 5:0 equal parameter `POOL_CODE` (default 0x10) and bits 20:18 equal parameter `MINOR_CODE` (default 3). Any other word leaves every register unchanged.
- R2: When padding bits 22:21 are not both zero, the instruction changes no register.
- R3: Register index 0 reads as zero, both as a source and on the read port. An instruction with destination index 0 (bits 9:6) changes nothing.
- R4: The first source index is in bits 13:10 and the second in bits 17:14. Window code 0 (bits 25:23) writes the first source unchanged, and code 4 writes the second source unchanged.
- R5: Window codes 1, 2 and 3 write the 32-bit slice that starts 1, 2 or 3 bytes below the top of {first source, second source}.
- R6: When both source indices name the same non-zero register, codes 1 to 3 yield that register rotated left by 8, 16 or 24 bits.
- R7: Window codes 5, 6 and 7 leave the destination unchanged.
- R8: The destination takes its new value on the clock edge that samples the valid instruction. The read port shows the old value before that edge and the new value after it.
- R9: Synchronous active-high `rst` clears every register to zero. A host write lands on the next edge, and a host write to index 0 is discarded.
- R10: When a host write and an instruction result target the same register in one cycle, the instruction result is kept. Writes to different registers both land.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| host_we | input | 1 | Host register write enable |
| host_waddr | input | 4 | Host write register index |
| host_wdata | input | 32 | Host write data |
| rd_addr | input | 4 | Read port register index |
| rd_data | output | 32 | Read port data (combinational) |

## Verification
The main function is tried with two distinct operands under every window code, so each of the five slices gets its own expected word. Using one register as both sources separates a true byte funnel from a rotation special case. A zero register on either side shows that index 0 feeds zero bytes into the stream. Words with bad padding, bad codes, a zero destination or an oversized window code are followed by a read of the destination, which tells a no-op from a stray write. A cycle with a host write and an instruction on the same register shows which writer wins.

// File: rtl/balign_pkg.sv
package balign_pkg;

    localparam int INSN_W = 32;
    localparam logic [5:0] MAJOR_CODE = 6'h1C;

    // Field order matches bit positions 31..0 of the instruction word.
    typedef struct packed {
        logic [5:0] major;    // 31:26
        logic [2:0] win;      // 25:23
        logic [1:0] pad;      // 22:21
        logic [2:0] minor;    // 20:18
        logic [3:0] sec_idx;  // 17:14
        logic [3:0] fst_idx;  // 13:10
        logic [3:0] dst_idx;  // 9:6
        logic [5:0] pool;     // 5:0
    } insn_t;

endpackage

// File: rtl/balign_decode.sv
module balign_decode
    import balign_pkg::*;
#(
    parameter logic [5:0] POOL_CODE  = 6'h10,
    parameter logic [2:0] MINOR_CODE = 3'd3,
    parameter int         NBYTES     = 4
) (
    input  logic              valid,
    input  logic [INSN_W-1:0] word,
    output logic [3:0]        fst_idx,
    output logic [3:0]        sec_idx,
    output logic [3:0]        dst_idx,
    output logic [2:0]        win,
    output logic              we
);

    insn_t f;
    logic  id_ok;
    logic  form_ok;

    always_comb begin
        f       = insn_t'(word);
        id_ok   = (f.major == MAJOR_CODE) && (f.pool == POOL_CODE) &&
                  (f.minor == MINOR_CODE);
        form_ok = (f.pad == 2'b00) && (f.dst_idx != 4'd0) &&
                  (int'(f.win) <= NBYTES);
        we      = valid && id_ok && form_ok;
        fst_idx = f.fst_idx;
        sec_idx = f.sec_idx;
        dst_idx = f.dst_idx;
        win     = f.win;
    end

endmodule

// File: rtl/balign_funnel.sv
module balign_funnel #(
    parameter int NBYTES = 4,
    parameter int WIN_W  = 3
) (
    input  logic [8*NBYTES-1:0] hi,
    input  logic [8*NBYTES-1:0] lo,
    input  logic [WIN_W-1:0]    shift,
    output logic [8*NBYTES-1:0] y
);

    localparam int SBYTES = 2 * NBYTES;

    logic [8*SBYTES-1:0] stream;
    logic [7:0]          sb   [SBYTES];
    logic [7:0]          ob   [NBYTES];

    assign stream = {hi, lo};

    // sb[0] is the most significant byte of the stream.
    for (genvar i = 0; i < SBYTES; i++) begin : g_split
        assign sb[i] = stream[(SBYTES-1-i)*8 +: 8];
    end

    always_comb begin
        for (int k = 0; k < NBYTES; k++) begin
            ob[k] = 8'h00;
            for (int j = 0; j <= NBYTES; j++) begin
                if (int'(shift) == j) begin
                    ob[k] = sb[k+j];
                end
            end
        end
    end

    for (genvar k = 0; k < NBYTES; k++) begin : g_pack
        assign y[(NBYTES-1-k)*8 +: 8] = ob[k];
    end

endmodule

// File: rtl/balign_regfile.sv
module balign_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inst_we,
    input  logic [IDX_W-1:0]  inst_idx,
    input  logic [DATA_W-1:0] inst_data,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [DATA_W-1:0] host_data,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] rc_data
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] r;
    } rf_t;

    rf_t rf_d;
    rf_t rf_q;

    always_comb begin
        rf_d = rf_q;
        if (host_we) begin
            rf_d.r[host_idx] = host_data;
        end
        // Instruction result is applied last so it wins a same-index clash.
        if (inst_we) begin
            rf_d.r[inst_idx] = inst_data;
        end
        rf_d.r[0] = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign ra_data = (ra_idx == '0) ? '0 : rf_q.r[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : rf_q.r[rb_idx];
    assign rc_data = (rc_idx == '0) ? '0 : rf_q.r[rc_idx];

endmodule

// File: rtl/byte_align_unit.sv
module byte_align_unit #(
    parameter int         DATA_W     = 32,
    parameter int         NREG       = 16,
    parameter logic [5:0] POOL_CODE  = 6'h10,
    parameter logic [2:0] MINOR_CODE = 3'd3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    input  logic [31:0]       instr_word,
    input  logic              host_we,
    input  logic [3:0]        host_waddr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [3:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam int NBYTES = DATA_W / 8;
    localparam int IDX_W  = $clog2(NREG);
    localparam int WIN_W  = 3;

    logic [3:0]        fst_idx;
    logic [3:0]        sec_idx;
    logic [3:0]        res_idx;
    logic [WIN_W-1:0]  win;
    logic              res_we;
    logic [DATA_W-1:0] src_hi_data;
    logic [DATA_W-1:0] src_lo_data;
    logic [DATA_W-1:0] res_data;

    balign_decode #(
        .POOL_CODE  (POOL_CODE),
        .MINOR_CODE (MINOR_CODE),
        .NBYTES     (NBYTES)
    ) u_dec (
        .valid   (instr_valid),
        .word    (instr_word),
        .fst_idx (fst_idx),
        .sec_idx (sec_idx),
        .dst_idx (res_idx),
        .win     (win),
        .we      (res_we)
    );

    balign_funnel #(
        .NBYTES (NBYTES),
        .WIN_W  (WIN_W)
    ) u_fun (
        .hi    (src_hi_data),
        .lo    (src_lo_data),
        .shift (win),
        .y     (res_data)
    );

    balign_regfile #(
        .DATA_W (DATA_W),
        .NREG   (NREG),
        .IDX_W  (IDX_W)
    ) u_rf (
        .clk       (clk),
        .rst       (rst),
        .inst_we   (res_we),
        .inst_idx  (res_idx),
        .inst_data (res_data),
        .host_we   (host_we),
        .host_idx  (host_waddr),
        .host_data (host_wdata),
        .ra_idx    (fst_idx),
        .ra_data   (src_hi_data),
        .rb_idx    (sec_idx),
        .rb_data   (src_lo_data),
        .rc_idx    (rd_addr),
        .rc_data   (rd_data)
    );

endmodule

// File: rtl/balign_checker.sv
module balign_checker #(
    parameter int DATA_W = 32,
    parameter int NBYTES = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              instr_valid,
    input logic [31:0]       instr_word,
    input logic              host_we,
    input logic [3:0]        host_waddr,
    input logic [DATA_W-1:0] host_wdata,
    input logic [3:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              res_we,
    input logic [3:0]        res_idx,
    input logic [DATA_W-1:0] res_data,
    input logic [DATA_W-1:0] src_hi_data
);

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !instr_valid |-> !res_we); // R1

    AST_MAJOR_MISMATCH: assert property (@(posedge clk) disable iff (rst)
        (instr_word[31:26] != 6'h1C) |-> !res_we); // R1

    AST_PAD_NOOP: assert property (@(posedge clk) disable iff (rst)
        (instr_word[22:21] != 2'b00) |-> !res_we); // R2

    AST_DST_ZERO_NOOP: assert property (@(posedge clk) disable iff (rst)
        (instr_word[9:6] == 4'd0) |-> !res_we); // R3

    AST_READ_ZERO_REG: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 4'd0) |-> (rd_data == '0)); // R3

    AST_WIN0_PASSES_FIRST: assert property (@(posedge clk) disable iff (rst)
        (res_we && instr_word[25:23] == 3'd0) |-> (res_data == src_hi_data)); // R4

    AST_BAD_WIN_NOOP: assert property (@(posedge clk) disable iff (rst)
        (int'(instr_word[25:23]) > NBYTES) |-> !res_we); // R7

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (rst)
        res_we |=> (rd_addr != $past(res_idx)) || (rd_data == $past(res_data))); // R8

    AST_HOST_NEXT: assert property (@(posedge clk) disable iff (rst)
        (host_we && host_waddr != 4'd0 && !(res_we && res_idx == host_waddr))
        |=> (rd_addr != $past(host_waddr)) || (rd_data == $past(host_wdata))); // R9

endmodule

bind byte_align_unit balign_checker #(
    .DATA_W (DATA_W),
    .NBYTES (NBYTES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .instr_valid (instr_valid),
    .instr_word  (instr_word),
    .host_we     (host_we),
    .host_waddr  (host_waddr),
    .host_wdata  (host_wdata),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .res_we      (res_we),
    .res_idx     (res_idx),
    .res_data    (res_data),
    .src_hi_data (src_hi_data)
);

// File: tb/byte_align_unit_tb.sv
module byte_align_unit_tb;

    localparam logic [5:0] POOL  = 6'h10;
    localparam logic [2:0] MINOR = 3'd3;
    localparam logic [5:0] MAJOR = 6'h1C;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_valid = 1'b0;
    logic [31:0] instr_word = '0;
    logic        host_we = 1'b0;
    logic [3:0]  host_waddr = '0;
    logic [31:0] host_wdata = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] model [16];

    typedef struct {
        logic [3:0]  idx;
        logic [31:0] exp;
        string       req;
    } sb_item_t;

    sb_item_t sb_q[$];

    always #4 clk = ~clk;

    byte_align_unit u_dut (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_word  (instr_word),
        .host_we     (host_we),
        .host_waddr  (host_waddr),
        .host_wdata  (host_wdata),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data)
    );

    function automatic logic [31:0] enc(logic [2:0] w, logic [1:0] pad, logic [3:0] sec,
                                        logic [3:0] fst, logic [3:0] dst, logic [5:0] pool,
                                        logic [2:0] minor, logic [5:0] major);
        return {major, w, pad, minor, sec, fst, dst, pool};
    endfunction

    // Monitor: pops expected register contents and compares at the read port.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                sb_item_t it;
                it = sb_q[0];
                rd_addr = it.idx;
                #1;
                n_run++;
                if (rd_data !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: reg %0d actual %08h expected %08h",
                             it.req, it.idx, rd_data, it.exp);
                end
                void'(sb_q.pop_front());
            end
        end
    end

    task automatic expect_reg(logic [3:0] idx, logic [31:0] exp, string req);
        sb_item_t it;
        it.idx = idx;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic host_write(logic [3:0] idx, logic [31:0] val);
        @(negedge clk);
        host_we = 1'b1; host_waddr = idx; host_wdata = val;
        @(negedge clk);
        host_we = 1'b0;
        if (idx != 4'd0) model[idx] = val;
    endtask

    // Driver: issues one word, updates the model from the requirements, queues the check.
    task automatic run_op(logic [2:0] w, logic [1:0] pad, logic [3:0] fst, logic [3:0] sec,
                          logic [3:0] dst, string req, logic [5:0] pool = POOL,
                          logic [2:0] minor = MINOR, logic [5:0] major = MAJOR);
        logic [63:0] s;
        bit legal;
        legal = (major == MAJOR) && (pool == POOL) && (minor == MINOR) &&
                (pad == 2'b00) && (dst != 4'd0) && (w <= 3'd4);
        s = {model[fst], model[sec]} << (8 * int'(w));
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = enc(w, pad, sec, fst, dst, pool, minor, major);
        @(negedge clk);
        instr_valid = 1'b0;
        instr_word  = '0;
        if (legal) model[dst] = s[63:32];
        expect_reg(dst, model[dst], req);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        expect_reg(4'd1, 32'h0, "R9");
        expect_reg(4'd7, 32'h0, "R9");
        expect_reg(4'd15, 32'h0, "R9");

        host_write(4'd1, 32'h11223344);
        host_write(4'd2, 32'hAABBCCDD);
        host_write(4'd3, 32'h01020304);
        host_write(4'd15, 32'hDEADBEEF);
        host_write(4'd0, 32'hFFFFFFFF);
        expect_reg(4'd0, 32'h0, "R9");
        expect_reg(4'd1, 32'h11223344, "R9");
        expect_reg(4'd15, 32'hDEADBEEF, "R9");

        // R4 pass-through windows
        run_op(3'd0, 2'b00, 4'd1, 4'd2, 4'd4, "R4");
        expect_reg(4'd4, 32'h11223344, "R4");
        run_op(3'd4, 2'b00, 4'd1, 4'd2, 4'd4, "R4");
        expect_reg(4'd4, 32'hAABBCCDD, "R4");

        // R5 straddling windows
        run_op(3'd1, 2'b00, 4'd1, 4'd2, 4'd5, "R5");
        expect_reg(4'd5, 32'h223344AA, "R5");
        run_op(3'd2, 2'b00, 4'd1, 4'd2, 4'd6, "R5");
        expect_reg(4'd6, 32'h3344AABB, "R5");
        run_op(3'd3, 2'b00, 4'd1, 4'd2, 4'd7, "R5");
        expect_reg(4'd7, 32'h44AABBCC, "R5");
        run_op(3'd3, 2'b00, 4'd2, 4'd1, 4'd7, "R5");
        expect_reg(4'd7, 32'hDD112233, "R5");

        // R6 same register on both sides
        run_op(3'd1, 2'b00, 4'd3, 4'd3, 4'd8, "R6");
        expect_reg(4'd8, 32'h02030401, "R6");
        run_op(3'd3, 2'b00, 4'd3, 4'd3, 4'd8, "R6");
        expect_reg(4'd8, 32'h04010203, "R6");

        // R3 zero register as a source
        run_op(3'd2, 2'b00, 4'd0, 4'd2, 4'd9, "R3");
        expect_reg(4'd9, 32'h0000AABB, "R3");
        run_op(3'd1, 2'b00, 4'd1, 4'd0, 4'd9, "R3");
        expect_reg(4'd9, 32'h22334400, "R3");
        run_op(3'd0, 2'b00, 4'd1, 4'd2, 4'd0, "R3");
        expect_reg(4'd0, 32'h0, "R3");

        // R2 padding, R7 bad window, R1 identity codes: destination keeps old value
        run_op(3'd1, 2'b01, 4'd1, 4'd2, 4'd15, "R2");
        run_op(3'd1, 2'b10, 4'd1, 4'd2, 4'd15, "R2");
        run_op(3'd5, 2'b00, 4'd1, 4'd2, 4'd15, "R7");
        run_op(3'd7, 2'b00, 4'd1, 4'd2, 4'd15, "R7");
        run_op(3'd0, 2'b00, 4'd1, 4'd2, 4'd15, "R1", 6'h11, MINOR, MAJOR);
        run_op(3'd0, 2'b00, 4'd1, 4'd2, 4'd15, "R1", POOL, 3'd2, MAJOR);
        run_op(3'd0, 2'b00, 4'd1, 4'd2, 4'd15, "R1", POOL, MINOR, 6'h1D);
        expect_reg(4'd15, 32'hDEADBEEF, "R1");

        // R8 old value before the edge, new value right after it
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = enc(3'd4, 2'b00, 4'd3, 4'd1, 4'd10, POOL, MINOR, MAJOR);
        begin
            sb_item_t it;
            it.idx = 4'd10; it.exp = 32'h0; it.req = "R8";
            sb_q.push_back(it);
        end
        @(negedge clk);
        instr_valid = 1'b0;
        model[10] = 32'h01020304;
        expect_reg(4'd10, 32'h01020304, "R8");

        // R10 host and instruction collide on one register; then on different ones
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = enc(3'd0, 2'b00, 4'd2, 4'd1, 4'd11, POOL, MINOR, MAJOR);
        host_we = 1'b1; host_waddr = 4'd11; host_wdata = 32'h55555555;
        @(negedge clk);
        instr_valid = 1'b0; host_we = 1'b0;
        expect_reg(4'd11, 32'h11223344, "R10");
        @(negedge clk);
        instr_valid = 1'b1;
        instr_word  = enc(3'd4, 2'b00, 4'd2, 4'd1, 4'd12, POOL, MINOR, MAJOR);
        host_we = 1'b1; host_waddr = 4'd13; host_wdata = 32'h66666666;
        @(negedge clk);
        instr_valid = 1'b0; host_we = 1'b0;
        expect_reg(4'd12, 32'hAABBCCDD, "R10");
        expect_reg(4'd13, 32'h66666666, "R10");

        // R9 reset clears registers again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_reg(4'd1, 32'h0, "R9");
        expect_reg(4'd12, 32'h0, "R9");

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule